// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive side of an Ethernet MAC and decides, for every incoming frame, whether the frame is kept or dropped. It observes the destination address one byte per accepted cycle, starting at a byte flagged as the first of a frame. While the bytes arrive it folds them into a running reflected CRC-32. Once the sixth byte is in, it produces a single-cycle decision.

Frames whose destination has the group bit set are looked up in a 64-bit hash table, which is laid out as four 16-bit words. The lookup uses six bits of the CRC. A frame whose group bit is clear is compared with the programmed station address. The all-ones address always passes. A promiscuous control passes every frame. A hash-enable control gates the table lookup.

The surrounding MAC supplies the table and station address as static configuration. It consumes the decision strobe to keep or discard the frame body. Frame storage and FCS checking live elsewhere.

Top module: `mhf_top`

## Requirements
- R1: After reset `decideVld` and `decideAccept` are 0, and no decision appears until six address bytes have been taken after a first-byte marker.
- R2: `decideVld` is high for exactly one cycle: the cycle after the clock edge that takes the sixth address byte. Bytes beyond the sixth have no effect until the next first-byte marker. `decideAccept` is 0 whenever `decideVld` is 0.
- R3: A byte with `byteFirst` set always restarts address collection, even in the middle of an address. Earlier partial bytes are discarded.
- R4: The hash index is bits 31:26 of a CRC register. The register starts at all ones and takes each address byte LSB first with the reflected polynomial 0xEDB88320. No final inversion is applied.
- R5: With `hashEn`=1, a frame whose first address byte has bit 0 = 1 (group frame) is accepted exactly when the table bit is set. Index bits 5:4 select table word k = `hashTable[16k+15:16k]`, and index bits 3:0 select the bit within that word.
- R6: With `hashEn`=0 and promiscuous mode off, a group frame that is not broadcast is rejected whatever the table holds.
- R7: A frame whose first address byte has bit 0 = 0 is accepted exactly when its address equals `stationAddr`. `stationAddr[47:32]` holds bytes 1 and 2 (byte 1 in the high half), `[31:16]` holds bytes 3 and 4, and `[15:0]` holds bytes 5 and 6. The hash table has no effect on such frames.
- R8: The broadcast address FF:FF:FF:FF:FF:FF is accepted regardless of `hashEn` and the table.
- R9: With `promiscEn`=1 every frame is accepted.
- R10: Idle cycles (`byteValid`=0) between address bytes do not change the result or its timing relative to the sixth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | Destination byte present this cycle |
| byteFirst | input | 1 | Marks the first destination byte of a frame |
| byteData | input | 8 | Destination address byte |
| promiscEn | input | 1 | Accept all frames |
| hashEn | input | 1 | Enable hash table lookup for group frames |
| hashTable | input | 64 | Four 16-bit table words, word k at bits 16k+15:16k |
| stationAddr | input | 48 | Station address, first byte in bits 47:40 |
| decideVld | output | 1 | One-cycle decision strobe |
| decideAccept | output | 1 | Frame accepted (valid with decideVld) |

## Verification
Two things can meet in one cycle. A decision strobe can coincide with a new first-byte marker, and a restart marker can arrive while an address is still half collected. The bench provokes the first by sending addresses back to back with no idle cycle, so the next frame's first byte is taken in the very cycle the previous decision is visible. It provokes the second by cutting an address after three bytes with a new marker. A behavioural model built on a byte queue predicts the strobe and the accept value on every clock, and any mismatch in either cycle is reported against the requirement under test.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFirst;
    logic loadNext;
    logic decide;
  } mhfCtl_t;

  // one byte through the reflected CRC, LSB first
  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] crcIn,
                                               input logic [7:0] dataIn);
    logic [CRC_W-1:0] acc;
    acc = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (acc[0] ^ dataIn[i]) acc = (acc >> 1) ^ CRC_POLY;
      else                    acc = acc >> 1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    byteValid,
  input  logic    byteFirst,
  output mhfCtl_t ctl
);

  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_IDLE = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] gotCnt;
  logic             collecting;

  assign collecting = (gotCnt < CNT_IDLE);

  always_comb begin
    ctl = '0;
    if (byteValid) begin
      if (byteFirst) begin
        ctl.loadFirst = 1'b1;
        ctl.decide    = (ADDR_BYTES == 1);
      end else if (collecting) begin
        ctl.loadNext = 1'b1;
        ctl.decide   = (gotCnt == CNT_LAST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gotCnt <= CNT_IDLE;
    else if (ctl.loadFirst) gotCnt <= CNT_ONE;
    else if (ctl.loadNext)  gotCnt <= gotCnt + CNT_ONE;
  end

  // R3: a first-byte marker restarts the count
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byteValid && byteFirst) |=> (gotCnt == CNT_ONE));

  // R2: count never runs past the address length
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gotCnt <= CNT_IDLE);

  // R10: idle cycles never load a byte
  assert_idle_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !byteValid |=> $stable(gotCnt));

  assert_one_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.loadFirst, ctl.loadNext}));

endmodule

// File: rtl/mhf_datapath.sv
module mhf_datapath
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned TBL_WORDS  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [7:0]                    byteData,
  input  mhfCtl_t                       ctl,
  input  logic                          promiscEn,
  input  logic                          hashEn,
  input  logic [TBL_WORDS*WORD_W-1:0]   hashTable,
  input  logic [ADDR_BYTES*8-1:0]       stationAddr,
  output logic                          decideVld,
  output logic                          decideAccept
);

  localparam int unsigned ADDR_W   = ADDR_BYTES * 8;
  localparam int unsigned TBL_BITS = TBL_WORDS * WORD_W;
  localparam int unsigned IDX_W    = $clog2(TBL_BITS);
  localparam int unsigned SEL_W    = $clog2(TBL_WORDS);
  localparam int unsigned BIT_W    = $clog2(WORD_W);

  logic [CRC_W-1:0]  crcReg, crcBase, crcNext;
  logic [ADDR_W-1:0] addrReg, addrBase, addrNext;
  logic [IDX_W-1:0]  hashIdx;
  logic [SEL_W-1:0]  wordSel;
  logic [BIT_W-1:0]  bitSel;
  logic [WORD_W-1:0] tblWord [TBL_WORDS];
  logic [WORD_W-1:0] selWord;
  logic              tableHit, isGroup, isBcast, stnHit, acceptNow;

  // slice the flat table into its words
  for (genvar g = 0; g < TBL_WORDS; g++) begin : g_words
    assign tblWord[g] = hashTable[g*WORD_W +: WORD_W];
  end

  always_comb begin
    crcBase  = ctl.loadFirst ? '1 : crcReg;
    crcNext  = crcStep(crcBase, byteData);
    addrBase = ctl.loadFirst ? '0 : addrReg;
    addrNext = {addrBase[ADDR_W-9:0], byteData};
  end

  assign hashIdx  = crcNext[CRC_W-1 -: IDX_W];
  assign wordSel  = hashIdx[IDX_W-1 -: SEL_W];
  assign bitSel   = hashIdx[BIT_W-1:0];
  assign selWord  = tblWord[wordSel];
  assign tableHit = selWord[bitSel];

  assign isGroup   = addrNext[ADDR_W-8];
  assign isBcast   = &addrNext;
  assign stnHit    = (addrNext == stationAddr);
  assign acceptNow = promiscEn | isBcast | (isGroup ? (hashEn & tableHit) : stnHit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcReg  <= '1;
      addrReg <= '0;
    end else if (ctl.loadFirst || ctl.loadNext) begin
      crcReg  <= crcNext;
      addrReg <= addrNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decideVld    <= 1'b0;
      decideAccept <= 1'b0;
    end else begin
      decideVld    <= ctl.decide;
      decideAccept <= ctl.decide & acceptNow;
    end
  end

  assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.decide |=> decideVld);

  assert_no_stray_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.decide |=> (!decideVld && !decideAccept));

  assert_promisc_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.decide && promiscEn) |=> decideAccept);

  assert_bcast_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.decide && isBcast) |=> decideAccept);

  assert_hash_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.decide && !promiscEn && !hashEn && isGroup && !isBcast) |=> !decideAccept);

endmodule

// File: rtl/mhf_top.sv
module mhf_top
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned TBL_WORDS  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        byteValid,
  input  logic                        byteFirst,
  input  logic [7:0]                  byteData,
  input  logic                        promiscEn,
  input  logic                        hashEn,
  input  logic [TBL_WORDS*WORD_W-1:0] hashTable,
  input  logic [ADDR_BYTES*8-1:0]     stationAddr,
  output logic                        decideVld,
  output logic                        decideAccept
);

  mhfCtl_t ctl;

  mhf_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .byteValid (byteValid),
    .byteFirst (byteFirst),
    .ctl       (ctl)
  );

  mhf_datapath #(
    .ADDR_BYTES (ADDR_BYTES),
    .WORD_W     (WORD_W),
    .TBL_WORDS  (TBL_WORDS)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .byteData     (byteData),
    .ctl          (ctl),
    .promiscEn    (promiscEn),
    .hashEn       (hashEn),
    .hashTable    (hashTable),
    .stationAddr  (stationAddr),
    .decideVld    (decideVld),
    .decideAccept (decideAccept)
  );

  // R1: nothing is decided while the interface is silent
  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !byteValid |=> !decideVld);

endmodule

// File: tb/mhf_top_tb.sv
module mhf_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byteValid = 1'b0;
  logic        byteFirst = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic        promiscEn = 1'b0;
  logic        hashEn = 1'b0;
  logic [63:0] hashTable = 64'h0;
  logic [47:0] stationAddr = 48'h0200_1122_3344;
  logic        decideVld, decideAccept;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string curTag = "R2";

  // reference model state
  byte unsigned mBytes[$];
  bit    mCollect = 0;
  bit    expVld = 0;
  bit    expAcc = 0;
  string expTag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  mhf_top u_dut (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteFirst(byteFirst),
    .byteData(byteData), .promiscEn(promiscEn), .hashEn(hashEn),
    .hashTable(hashTable), .stationAddr(stationAddr),
    .decideVld(decideVld), .decideAccept(decideAccept)
  );

  function automatic int refIdx(input logic [47:0] a);
    int unsigned c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      c = c ^ int'(a[47-8*k -: 8]);
      for (int b = 0; b < 8; b++)
        c = (c >> 1) ^ ((c & 1) ? 32'hEDB88320 : 32'h0);
    end
    return int'(c >> 26);
  endfunction

  function automatic logic [47:0] queueAddr();
    logic [47:0] a;
    a = '0;
    for (int k = 0; k < 6; k++) a = {a[39:0], mBytes[k]};
    return a;
  endfunction

  function automatic bit refAccept(input logic [47:0] a);
    int idx;
    if (promiscEn) return 1;
    if (a == 48'hFFFF_FFFF_FFFF) return 1;
    if (a[40]) begin
      idx = refIdx(a);
      return hashEn && hashTable[(idx / 16) * 16 + (idx % 16)];
    end
    return a == stationAddr;
  endfunction

  function automatic string refTag(input logic [47:0] a);
    if (promiscEn) return "R9";
    if (a == 48'hFFFF_FFFF_FFFF) return "R8";
    if (a[40]) return hashEn ? "R4 R5" : "R6";
    return "R7";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      expVld = 0; expAcc = 0; mCollect = 0; mBytes.delete();
    end else begin
      expVld = 0; expAcc = 0;
      if (byteValid) begin
        if (byteFirst) begin
          mBytes.delete(); mBytes.push_back(byteData); mCollect = 1;
        end else if (mCollect) begin
          mBytes.push_back(byteData);
        end
        if (mCollect && mBytes.size() == 6) begin
          expVld = 1;
          expAcc = refAccept(queueAddr());
          expTag = refTag(queueAddr());
          mCollect = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(decideVld == expVld, {curTag, " strobe"}, decideVld, expVld);
      if (expVld) check(decideAccept == expAcc, {expTag, " accept"}, decideAccept, expAcc);
      else        check(decideAccept == 1'b0, "R2 accept idle", decideAccept, 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic sendByte(input logic [7:0] b, input bit first);
    byteValid = 1'b1; byteFirst = first; byteData = b;
    @(negedge clk);
    byteValid = 1'b0; byteFirst = 1'b0;
  endtask

  task automatic sendAddr(input logic [47:0] a, input int gap, input int extra, input int idleAfter);
    for (int k = 0; k < 6; k++) begin
      sendByte(a[47-8*k -: 8], k == 0);
      repeat (gap) @(negedge clk);
    end
    for (int e = 0; e < extra; e++) sendByte(8'hA5 ^ 8'(e), 1'b0);
    repeat (idleAfter) @(negedge clk);
  endtask

  localparam logic [47:0] GRP_A = 48'h0100_5E00_00FB;
  localparam logic [47:0] GRP_B = 48'h3333_0000_0001;

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    check(decideVld == 1'b0 && decideAccept == 1'b0, "R1 reset", decideVld, 0);
    rst_n = 1'b1;
    @(negedge clk);

    curTag = "R7";
    sendAddr(stationAddr, 0, 0, 2);            // unicast match
    sendAddr(48'h0200_1122_3345, 0, 0, 2);     // unicast mismatch
    hashTable = '1; hashEn = 1'b1;
    sendAddr(48'h0200_1122_3345, 0, 0, 2);     // R7: table ignored for unicast

    curTag = "R5";
    hashTable = '0;
    sendAddr(GRP_A, 0, 0, 2);                  // R5 empty table rejects
    idx = refIdx(GRP_A);
    hashTable = 64'h1 << idx;
    sendAddr(GRP_A, 0, 0, 2);                  // R4 R5 single bit accepts
    hashTable = ~(64'h1 << idx);
    sendAddr(GRP_A, 0, 0, 2);                  // R5 every other bit rejects
    hashTable = '1;
    sendAddr(GRP_B, 0, 0, 2);                  // R5 all ones accepts

    curTag = "R6";
    hashEn = 1'b0;
    sendAddr(GRP_B, 0, 0, 2);

    curTag = "R8";
    hashTable = '0;
    sendAddr(48'hFFFF_FFFF_FFFF, 0, 0, 2);

    curTag = "R9";
    promiscEn = 1'b1;
    sendAddr(48'h0A0B_0C0D_0E0F, 0, 0, 2);
    sendAddr(GRP_A, 0, 0, 2);
    promiscEn = 1'b0;

    curTag = "R10";
    sendAddr(stationAddr, 3, 0, 2);            // gaps between bytes

    curTag = "R2";
    sendAddr(stationAddr, 0, 4, 3);            // trailing bytes ignored

    curTag = "R3";
    for (int k = 0; k < 3; k++) sendByte(8'hFF, k == 0);
    sendAddr(stationAddr, 0, 0, 2);            // restart mid-address
    sendByte(8'h02, 1'b1); sendByte(8'h00, 1'b0);
    sendAddr(48'hFFFF_FFFF_FFFF, 1, 0, 2);

    curTag = "R2 R3";
    hashEn = 1'b1; hashTable = '1;
    sendAddr(stationAddr, 0, 0, 0);            // back to back: next marker meets strobe
    sendAddr(GRP_B, 0, 0, 0);
    sendAddr(48'h0200_0000_0000, 0, 0, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule